// File: doc/BRIEF.md
# Two-Wire Register Port Slave

This block lets an external two-wire bus master read and write a small bank of 8-bit control registers inside the chip. SCL and SDA are sampled on the system clock. Each line passes through a synchronizer and a short majority vote. Bus conditions are then recovered from the filtered lines. These are start, repeated start, stop, and the rising and falling clock edges. SDA is driven only as an open-drain low: `sda_oe_o` high means the pad pulls the line low.

A transfer opens with the device address and a direction bit. A write transfer carries a register pointer byte, followed by any number of data bytes. Each data byte lands at the pointer, and the pointer then steps up by one. At the top register the pointer stops advancing. A pointer byte outside the bank is refused. A read transfer streams registers out, starting from the pointer left by earlier traffic, and stops when the master declines a byte. The usual way to read a chosen register is a write of the pointer, then a repeated start with the read address. All register contents are presented in parallel on `ctrl_regs_o` for the rest of the chip.

Top module: `regport_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high opens a transfer, and a rising SDA while SCL is high closes it and releases SDA. Bytes clocked without a preceding start are never acknowledged.
- R2: The first byte after a start is seven address bits, MSB first, then a direction bit (1 = read, 0 = write). The device address is 0b100110 followed by `addr_lsb_i`, so write/read bytes are 0x98/0x99 with the strap low and 0x9A/0x9B with it high. On a match the slave pulls SDA low during the 9th SCL pulse.
- R3: On an address mismatch SDA stays released, and later bytes are neither acknowledged nor written until the next start.
- R4: In a write transfer the byte after the address loads the register pointer. Each later byte is stored at the pointer, acknowledged, and the pointer then increments by one. Register n appears on `ctrl_regs_o[8n+7:8n]`.
- R5: The pointer saturates at register 0x0F. Further written bytes all overwrite register 0x0F.
- R6: A pointer byte above 0x0F is not acknowledged. The transfer is then ignored, with no register or pointer change.
- R7: A read transfer returns the register at the current pointer, then increments the pointer after each byte sent, saturating at 0x0F.
- R8: A master NACK after a read byte ends the data phase. The slave leaves SDA released, and the next start is served normally.
- R9: A repeated start resets address decoding, so a write of the pointer followed by a read needs no stop in between.
- R10: The slave changes its SDA drive only while SCL is low, after a falling SCL edge.
- R11: After reset all registers are 0x00, the pointer is 0x00 and SDA is released.
- R12: A single-clock-cycle pulse on SCL is filtered out and does not disturb bit counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_lsb_i | input | 1 | Strap that supplies address bit 0 |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| ctrl_regs_o | output | 128 | All 16 registers, register n at bits 8n+7:8n |

## Verification
A wrong bit count or phase state shows up at the port within one byte. Either the ACK appears one SCL pulse early or late, or it is missing, or read data comes back shifted by a bit. A corrupted pointer is visible in the next write, as a byte landing in the wrong slot of `ctrl_regs_o`, or in the next read byte. A filter or edge fault shows as a lost or extra bit, and so as wrong data in the same transfer. The bench therefore compares every ACK bit and every read byte as it arrives. It also checks the register outputs after each write transfer.

// File: rtl/rp_pkg.sv
// Shared types for the register-port bus slave.
// Assumes: 8-bit bus bytes; the states below are the only protocol phases.
package rp_pkg;

    typedef logic [7:0] rp_byte_t;

    // Protocol phase of the transfer engine.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // not addressed; waits for a start
        ST_RX   = 3'd1,  // shifting in a byte from the master
        ST_ACK  = 3'd2,  // holding SDA low for the 9th pulse
        ST_TX   = 3'd3,  // shifting out a register byte
        ST_MACK = 3'd4   // sampling the master's ack bit
    } rp_state_e;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_PTR  = 2'd1,
        K_DATA = 2'd2
    } rp_kind_e;

endpackage

// File: rtl/rp_line_filter.sv
// Synchronizer plus majority-vote filter for one bus line.
// Assumes: the line idles high; the line is slow against clk, so a
// change must persist for more than half the vote taps to pass.
module rp_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(VOTE_TAPS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   taps_q;
    logic [CNT_W-1:0]       votes;
    logic                   line_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Keep the most recent synchronized samples for the vote.
    always_ff @(posedge clk) begin
        if (!rst_n) taps_q <= '1;
        else        taps_q <= {taps_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
    end

    // Count the high samples among the taps.
    always_comb begin
        votes = '0;
        for (int i = 0; i < VOTE_TAPS; i++) begin
            votes = votes + CNT_W'(taps_q[i]);
        end
    end

    // Register the majority decision as the clean line level.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= (votes > CNT_W'(VOTE_TAPS / 2));
    end

    assign line_o = line_q;
endmodule

// File: rtl/rp_bus_events.sv
// Recovers SCL edges and start/stop conditions from the filtered lines.
// Assumes: inputs are already synchronous and glitch-free; each event
// output is a single-cycle pulse.
module rp_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    // Remember the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // SDA moving during a stable SCL high phase is a bus condition.
    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/rp_reg_bank.sv
// Bank of control registers with one write port and one read port.
// Assumes: wr_addr and rd_addr stay below NUM_REGS.
module rp_reg_bank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Hold one register; load it when the write targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                regs[g] <= wr_data;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    assign rd_data = regs[rd_addr];
endmodule

// File: rtl/rp_xfer_fsm.sv
// Byte-level transfer engine: address match, pointer load, sequential
// write and read with a saturating pointer, ack generation.
// Assumes: event inputs are single-cycle pulses from rp_bus_events;
// rd_data reflects the register at ptr_o in the same cycle.
module rp_xfer_fsm
    import rp_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b100110,
    parameter int         NUM_REGS    = 16,
    localparam int        PTR_W       = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_in,
    input  logic             addr_lsb,
    input  rp_byte_t         rd_data,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output rp_byte_t         wr_data,
    output logic             sda_oe,
    output rp_state_e        state_o
);
    localparam logic [PTR_W-1:0] PTR_MAX  = PTR_W'(NUM_REGS - 1);
    localparam rp_byte_t         BYTE_MAX = 8'(NUM_REGS - 1);

    rp_state_e        state;
    rp_kind_e         kind;
    logic [2:0]       bit_cnt;
    logic             rx_full;
    rp_byte_t         rx_sr;
    rp_byte_t         tx_sr;
    logic             rw;
    logic             m_nack;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] ptr_next;

    // Pointer advance that stops at the top register.
    assign ptr_next = (ptr == PTR_MAX) ? ptr : ptr + PTR_W'(1);

    // Protocol sequencing; every SDA change follows an SCL fall or a bus condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= K_ADDR;
            bit_cnt <= '0;
            rx_full <= 1'b0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            rw      <= 1'b0;
            m_nack  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_RX;
                kind    <= K_ADDR;
                bit_cnt <= '0;
                rx_full <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                rx_full <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[6:0], sda_in};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) rx_full <= 1'b1;
                        end else if (scl_fall && rx_full) begin
                            rx_full <= 1'b0;
                            unique case (kind)
                                K_ADDR: begin
                                    if (rx_sr[7:1] == {DEV_ADDR_HI, addr_lsb}) begin
                                        rw     <= rx_sr[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                    end else begin
                                        state  <= ST_IDLE;
                                    end
                                end
                                K_PTR: begin
                                    if (rx_sr <= BYTE_MAX) begin
                                        ptr    <= rx_sr[PTR_W-1:0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                    end else begin
                                        state  <= ST_IDLE;
                                    end
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= rx_sr;
                                    ptr     <= ptr_next;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (kind == K_ADDR && rw) begin
                                sda_oe <= ~rd_data[7];
                                tx_sr  <= {rd_data[6:0], 1'b0};
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr_next;
                                state  <= ST_MACK;
                            end else begin
                                sda_oe <= ~tx_sr[7];
                                tx_sr  <= {tx_sr[6:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            m_nack <= sda_in;
                        end else if (scl_fall) begin
                            if (m_nack) begin
                                state <= ST_IDLE;
                            end else begin
                                bit_cnt <= '0;
                                sda_oe  <= ~rd_data[7];
                                tx_sr   <= {rd_data[6:0], 1'b0};
                                state   <= ST_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ptr_o   = ptr;
    assign state_o = state;
endmodule

// File: rtl/regport_i2c_slave.sv
// Top of the two-wire register-port slave: line filters, event
// detection, transfer engine and the register bank.
// Assumes: clk is much faster than SCL (at least ~16x); sda_oe_o drives
// an open-drain pad low when high.
module regport_i2c_slave #(
    parameter logic [5:0] DEV_ADDR_HI = 6'b100110,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2,
    parameter int         VOTE_TAPS   = 3,
    localparam int        PTR_W       = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  addr_lsb_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] ctrl_regs_o
);
    import rp_pkg::*;

    logic [1:0]       line_raw;
    logic [1:0]       line_f;
    logic             ev_scl_rise;
    logic             ev_scl_fall;
    logic             ev_start;
    logic             ev_stop;
    logic [PTR_W-1:0] reg_ptr;
    rp_byte_t         reg_rdata;
    logic             fsm_wr_en;
    logic [PTR_W-1:0] fsm_wr_addr;
    rp_byte_t         fsm_wr_data;
    rp_state_e        fsm_state;

    assign line_raw = {sda_i, scl_i};

    for (genvar i = 0; i < 2; i++) begin : g_line
        rp_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_TAPS  (VOTE_TAPS)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(line_raw[i]),
            .line_o(line_f[i])
        );
    end

    rp_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (line_f[0]),
        .sda_f    (line_f[1]),
        .scl_rise (ev_scl_rise),
        .scl_fall (ev_scl_fall),
        .start_det(ev_start),
        .stop_det (ev_stop)
    );

    rp_xfer_fsm #(
        .DEV_ADDR_HI(DEV_ADDR_HI),
        .NUM_REGS   (NUM_REGS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (ev_scl_rise),
        .scl_fall (ev_scl_fall),
        .start_det(ev_start),
        .stop_det (ev_stop),
        .sda_in   (line_f[1]),
        .addr_lsb (addr_lsb_i),
        .rd_data  (reg_rdata),
        .ptr_o    (reg_ptr),
        .wr_en    (fsm_wr_en),
        .wr_addr  (fsm_wr_addr),
        .wr_data  (fsm_wr_data),
        .sda_oe   (sda_oe_o),
        .state_o  (fsm_state)
    );

    rp_reg_bank #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (8)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fsm_wr_en),
        .wr_addr  (fsm_wr_addr),
        .wr_data  (fsm_wr_data),
        .rd_addr  (reg_ptr),
        .rd_data  (reg_rdata),
        .regs_flat(ctrl_regs_o)
    );
endmodule

// File: rtl/regport_i2c_slave_chk.sv
// Protocol checker for regport_i2c_slave, attached by bind.
// Assumes: event signals are the single-cycle pulses of rp_bus_events.
module regport_i2c_slave_chk
    import rp_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ev_scl_rise,
    input logic                  ev_scl_fall,
    input logic                  ev_start,
    input logic                  ev_stop,
    input logic                  fsm_wr_en,
    input rp_state_e             fsm_state,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] ctrl_regs_o
);
    // R1: bus events are mutually exclusive.
    p_single_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_scl_rise, ev_scl_fall}));

    // R1: a stop leaves SDA released.
    p_release_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe_o);

    // R9: a (repeated) start leaves SDA released for the address byte.
    p_release_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_oe_o);

    // R3: while not addressed the slave never pulls SDA.
    p_quiet_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IDLE) |-> !sda_oe_o);

    // R4: every register write is acknowledged in the same cycle.
    p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_wr_en |-> sda_oe_o);

    // R4: registers change only two cycles after an SCL fall.
    p_regs_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ctrl_regs_o) |-> $past(ev_scl_fall, 2));

    // R10: the SDA drive changes only after an SCL fall or a bus condition.
    p_sda_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe_o) |-> ($past(ev_scl_fall) || $past(ev_start) || $past(ev_stop)));
endmodule

bind regport_i2c_slave regport_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_scl_rise(ev_scl_rise),
    .ev_scl_fall(ev_scl_fall),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .fsm_wr_en  (fsm_wr_en),
    .fsm_state  (fsm_state),
    .sda_oe_o   (sda_oe_o),
    .ctrl_regs_o(ctrl_regs_o)
);

// File: tb/regport_i2c_slave_test.sv
// Scoreboard bench: bus driver tasks queue expected ack bits and read
// bytes; a monitor process compares them with what the bus returns.
module regport_i2c_slave_test;
    localparam int Q = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic sda_oe;
    logic [127:0] regs_o;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    regport_i2c_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .addr_lsb_i (strap),
        .sda_oe_o   (sda_oe),
        .ctrl_regs_o(regs_o)
    );

    typedef struct { string req; int val; } item_t;

    int checks = 0;
    int fails = 0;
    item_t exp_q[$];
    int obs_q[$];
    event obs_ev;
    logic [7:0] mdl [16];
    int mptr = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: pop expected and observed items in order and compare.
    initial begin
        forever begin
            @(obs_ev);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t it;
                int a;
                it = exp_q.pop_front();
                a = obs_q.pop_front();
                chk(it.req, a, it.val);
            end
        end
    end

    // R10 observer: SDA drive must not move while SCL is high.
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic wait_q(int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (scl_m == 1'b0) begin
            sda_m = 1'b1; wait_q(1);
            scl_m = 1'b1; wait_q(2);
        end
        sda_m = 1'b0; wait_q(2);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(2);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic send_byte(logic [7:0] b, int exp_ack, string req, bit glitch = 1'b0);
        logic ack;
        exp_q.push_back('{req, exp_ack});
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(1);
            scl_m = 1'b1;
            if (glitch) begin
                wait_q(1);
                scl_m = 1'b0; @(negedge clk);
                scl_m = 1'b1; wait_q(1);
            end else begin
                wait_q(2);
            end
            scl_m = 1'b0; wait_q(1);
        end
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        ack = ~sda_bus;
        wait_q(1);
        scl_m = 1'b0; wait_q(1);
        obs_q.push_back(int'(ack));
        -> obs_ev;
    endtask

    task automatic recv_byte(logic [7:0] exp, bit m_ack, string req);
        logic [7:0] v = '0;
        exp_q.push_back('{req, int'(exp)});
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_q(1);
            scl_m = 1'b1; wait_q(1);
            v = {v[6:0], sda_bus};
            wait_q(1);
            scl_m = 1'b0;
        end
        wait_q(1);
        sda_m = ~m_ack; wait_q(1);
        scl_m = 1'b1; wait_q(2);
        scl_m = 1'b0; wait_q(1);
        sda_m = 1'b1;
        obs_q.push_back(int'(v));
        -> obs_ev;
        mptr = (mptr == 15) ? 15 : mptr + 1;
    endtask

    task automatic mdl_write(logic [7:0] d);
        mdl[mptr] = d;
        mptr = (mptr == 15) ? 15 : mptr + 1;
    endtask

    task automatic chk_reg(string req, int idx);
        chk(req, int'(regs_o[idx*8 +: 8]), int'(mdl[idx]));
    endtask

    task automatic chk_all_regs(string req);
        for (int i = 0; i < 16; i++) chk_reg(req, i);
    endtask

    task automatic finish_run();
        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Driver: stimulus sequence.
    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R11 reset state.
        chk("R11 sda released", int'(sda_oe), 0);
        chk_all_regs("R11 regs zero");

        // R1: a byte without a start is ignored.
        scl_m = 1'b0; wait_q(1);
        send_byte(8'h98, 0, "R1 no ack without start");
        bus_stop();

        // R2/R4: write three bytes from pointer 0x03.
        bus_start();
        send_byte(8'h98, 1, "R2 write address ack");
        send_byte(8'h03, 1, "R4 pointer ack");
        mptr = 3;
        send_byte(8'hA1, 1, "R4 data ack"); mdl_write(8'hA1);
        send_byte(8'hB2, 1, "R4 data ack"); mdl_write(8'hB2);
        send_byte(8'hC3, 1, "R4 data ack"); mdl_write(8'hC3);
        bus_stop();
        chk_reg("R4 reg3", 3); chk_reg("R4 reg4", 4); chk_reg("R4 reg5", 5);

        // R9/R7: pointer write, repeated start, sequential read.
        bus_start();
        send_byte(8'h98, 1, "R9 address ack");
        send_byte(8'h03, 1, "R9 pointer ack");
        mptr = 3;
        bus_start();
        send_byte(8'h99, 1, "R9 read address after repeated start");
        recv_byte(mdl[3], 1'b1, "R7 read byte 0");
        recv_byte(mdl[4], 1'b1, "R7 read byte 1");
        recv_byte(mdl[5], 1'b0, "R7 read byte 2");
        bus_stop();

        // R5: pointer saturates at 0x0F during writes.
        bus_start();
        send_byte(8'h98, 1, "R5 address ack");
        send_byte(8'h0E, 1, "R5 pointer ack");
        mptr = 14;
        send_byte(8'h11, 1, "R5 data ack"); mdl_write(8'h11);
        send_byte(8'h22, 1, "R5 data ack"); mdl_write(8'h22);
        send_byte(8'h33, 1, "R5 data ack"); mdl_write(8'h33);
        send_byte(8'h44, 1, "R5 data ack"); mdl_write(8'h44);
        bus_stop();
        chk_reg("R5 reg14", 14); chk_reg("R5 reg15", 15); chk_reg("R5 reg13", 13);

        // R7: reads at the top register repeat it.
        bus_start();
        send_byte(8'h99, 1, "R7 read address ack");
        recv_byte(mdl[15], 1'b1, "R7 saturated read 0");
        recv_byte(mdl[15], 1'b0, "R7 saturated read 1");
        bus_stop();

        // R6: out-of-range pointer is refused.
        bus_start();
        send_byte(8'h98, 1, "R6 address ack");
        send_byte(8'h10, 0, "R6 pointer 0x10 nack");
        send_byte(8'h77, 0, "R6 data after refused pointer");
        bus_stop();
        chk_all_regs("R6 regs unchanged");
        bus_start();
        send_byte(8'h99, 1, "R6 read address ack");
        recv_byte(mdl[15], 1'b0, "R6 pointer unchanged");
        bus_stop();

        // R3: wrong address is ignored.
        bus_start();
        send_byte(8'h9A, 0, "R3 mismatch nack");
        send_byte(8'h00, 0, "R3 pointer ignored");
        send_byte(8'hFF, 0, "R3 data ignored");
        bus_stop();
        chk_all_regs("R3 regs unchanged");

        // R2: strap moves the address.
        strap = 1'b1;
        repeat (5) @(negedge clk);
        bus_start();
        send_byte(8'h98, 0, "R2 old address nack with strap high");
        bus_stop();
        bus_start();
        send_byte(8'h9A, 1, "R2 strap address ack");
        send_byte(8'h01, 1, "R2 pointer ack");
        mptr = 1;
        send_byte(8'h5A, 1, "R2 data ack"); mdl_write(8'h5A);
        bus_stop();
        chk_reg("R2 reg1", 1);

        // R8: master NACK ends the read; SDA stays released.
        bus_start();
        send_byte(8'h9A, 1, "R8 address ack");
        send_byte(8'h01, 1, "R8 pointer ack");
        mptr = 1;
        bus_start();
        send_byte(8'h9B, 1, "R8 read address ack");
        recv_byte(mdl[1], 1'b0, "R8 read byte");
        wait_q(1);
        chk("R8 sda released after master nack", int'(sda_oe), 0);
        scl_m = 1'b1; wait_q(1);
        chk("R8 sda released in next pulse", int'(sda_oe), 0);
        scl_m = 1'b0; wait_q(1);
        bus_stop();
        bus_start();
        send_byte(8'h9B, 1, "R8 new transfer ack");
        recv_byte(mdl[2], 1'b0, "R8 new transfer read");
        bus_stop();

        // R12: one-cycle SCL pulses inside each high phase.
        bus_start();
        send_byte(8'h9A, 1, "R12 address ack");
        send_byte(8'h07, 1, "R12 pointer ack");
        mptr = 7;
        send_byte(8'h3C, 1, "R12 glitched data ack", 1'b1); mdl_write(8'h3C);
        bus_stop();
        chk_reg("R12 reg7", 7);
        chk_all_regs("R12 other regs intact");

        // R10: SDA drive never moved during SCL high.
        chk("R10 sda changes while scl high", oe_viol, 0);

        repeat (5) @(negedge clk);
        chk("R1 scoreboard drained", exp_q.size() + obs_q.size(), 0);
        finish_run();
    end
endmodule